// File: doc/BRIEF.md
# Hysteretic Cooling Fan Controller

This block decides whether a cooling fan runs, based on eight temperature sensors. On each valid strobe it takes the hottest of the eight readings, stores it as the current peak, and compares it against two thresholds. Reaching the upper threshold turns the fan on. Falling to the lower threshold turns it off. Between the two thresholds the fan keeps its previous state, so a temperature that hovers near one threshold does not make the fan chatter.

Readings are signed 16-bit words in tenths of a degree Celsius. Each change of the fan state raises a one-cycle event pulse, and the peak that caused the change is presented next to the pulse so that it can be logged. The block also flags when the stored peak reaches a shutdown level. That level sits above the fan-on point, so the fan starts before any shutdown logic acts. The shutdown logic itself is not part of this block.

Top module: `fan_ctrl_top`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, fan_on_o, event_o and shutdown_o are 0, and peak_o and event_temp_o are 0.
- R2: A strobe whose peak is at least ON_TEMP (default 700, which is 70.0 °C) sets fan_on_o to 1.
- R3: A strobe whose peak is at most OFF_TEMP (default 600) clears fan_on_o to 0.
- R4: A strobe whose peak lies strictly between OFF_TEMP and ON_TEMP leaves fan_on_o unchanged.
- R5: The peak is the maximum of the eight readings. Sensor j occupies bits 16*j+15 down to 16*j of temps_i, and any single sensor can drive the decision.
- R6: When valid_i is low, fan_on_o, peak_o, event_temp_o and shutdown_o keep their values.
- R7: event_o is high for exactly the one cycle in which fan_on_o has just changed, and in that cycle event_temp_o holds the peak that caused the change. A strobe that does not change fan_on_o raises no event.
- R8: shutdown_o is 1 exactly when the stored peak_o is at least SHUT_TEMP (default 750), whatever the state of the fan.
- R9: Readings are two's-complement signed, so an all-negative set yields the least negative reading as the peak.
- R10: All outputs are registered. A strobe sampled at a rising edge is visible on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: a new set of readings is present |
| temps_i | input | 128 | Eight signed readings in tenths of a degree, sensor j at bits [16j+15:16j] |
| fan_on_o | output | 1 | Fan enable |
| peak_o | output | 16 | Peak temperature from the last strobe |
| event_o | output | 1 | One-cycle pulse on each fan state change |
| event_temp_o | output | 16 | Peak that caused the latest fan state change |
| shutdown_o | output | 1 | Stored peak is at or above the shutdown threshold |

## Verification
The state that matters is the fan bit together with the stored peak. If the fan bit is wrong, it shows on fan_on_o at the first strobe that lands in the dead band, because the fan should hold there and does not. If a threshold comparison is wrong, it shows at the first strobe that hits exactly 600 or 700. A wrong maximum shows in peak_o one cycle after the strobe. The event pulse and the event temperature expose a missed or extra transition in that same cycle. The bench therefore compares every output on every clock against a behavioural model, and it drives readings exactly at each threshold and one tenth of a degree on either side.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int TEMP_W = 16;
  typedef logic signed [TEMP_W-1:0] temp_t;
  localparam temp_t TEMP_MIN = {1'b1, {(TEMP_W-1){1'b0}}};
endpackage

// File: rtl/fan_peak_tree.sv
module fan_peak_tree
  import fan_pkg::*;
#(
  parameter int N_SENS = 8
) (
  input  temp_t temp_i [N_SENS],
  output temp_t peak_o
);
  localparam int LVLS  = (N_SENS > 1) ? $clog2(N_SENS) : 1;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  // heap layout: root 0, children 2k+1 / 2k+2, leaves from LEAVES-1
  temp_t node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_SENS) begin : g_real
      assign node[LEAVES-1+j] = temp_i[j];
    end else begin : g_pad
      assign node[LEAVES-1+j] = TEMP_MIN;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    assign node[k] = (node[2*k+1] >= node[2*k+2]) ? node[2*k+1] : node[2*k+2];
  end

  assign peak_o = node[0];
endmodule

// File: rtl/fan_hyst.sv
module fan_hyst
  import fan_pkg::*;
#(
  parameter int ON_TEMP  = 700,
  parameter int OFF_TEMP = 600
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  temp_t peak_i,
  output logic  fan_o,
  output temp_t peak_o,
  output logic  event_o,
  output temp_t event_temp_o
);
  localparam temp_t ON_T  = temp_t'(ON_TEMP);
  localparam temp_t OFF_T = temp_t'(OFF_TEMP);

  logic  fan_q, fan_d, evt_q;
  temp_t peak_q, evt_temp_q;

  always_comb begin
    fan_d = fan_q;
    if (valid_i) begin
      if (peak_i >= ON_T)       fan_d = 1'b1;
      else if (peak_i <= OFF_T) fan_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fan_q      <= 1'b0;
      evt_q      <= 1'b0;
      peak_q     <= '0;
      evt_temp_q <= '0;
    end else begin
      fan_q <= fan_d;
      evt_q <= fan_d ^ fan_q;
      if (valid_i) peak_q <= peak_i;
      if (fan_d ^ fan_q) evt_temp_q <= peak_i;
    end
  end

  assign fan_o        = fan_q;
  assign peak_o       = peak_q;
  assign event_o      = evt_q;
  assign event_temp_o = evt_temp_q;

  assert_fan_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && peak_i >= ON_T) |=> fan_q);
  assert_fan_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && peak_i <= OFF_T) |=> !fan_q);
  assert_band_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && peak_i > OFF_T && peak_i < ON_T) |=> $stable(fan_q));
  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(fan_q) && $stable(peak_q) && $stable(evt_temp_q)));
  assert_event_temp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (evt_temp_q == peak_q));
endmodule

// File: rtl/fan_ctrl_top.sv
module fan_ctrl_top
  import fan_pkg::*;
#(
  parameter int N_SENS    = 8,
  parameter int ON_TEMP   = 700,
  parameter int OFF_TEMP  = 600,
  parameter int SHUT_TEMP = 750
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [N_SENS*TEMP_W-1:0]   temps_i,
  output logic                       fan_on_o,
  output logic signed [TEMP_W-1:0]   peak_o,
  output logic                       event_o,
  output logic signed [TEMP_W-1:0]   event_temp_o,
  output logic                       shutdown_o
);
  localparam temp_t SHUT_T = temp_t'(SHUT_TEMP);

  temp_t temp_arr [N_SENS];
  temp_t peak_now, peak_q, evt_temp;

  for (genvar j = 0; j < N_SENS; j++) begin : g_unpack
    assign temp_arr[j] = temp_t'(temps_i[j*TEMP_W +: TEMP_W]);
  end

  fan_peak_tree #(.N_SENS(N_SENS)) u_tree (
    .temp_i (temp_arr),
    .peak_o (peak_now)
  );

  fan_hyst #(.ON_TEMP(ON_TEMP), .OFF_TEMP(OFF_TEMP)) u_hyst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .peak_i       (peak_now),
    .fan_o        (fan_on_o),
    .peak_o       (peak_q),
    .event_o      (event_o),
    .event_temp_o (evt_temp)
  );

  assign peak_o       = peak_q;
  assign event_temp_o = evt_temp;
  assign shutdown_o   = (peak_q >= SHUT_T);

  for (genvar j = 0; j < N_SENS; j++) begin : g_chk
    assert_peak_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (peak_o >= $past(temp_arr[j])));
  end

  assert_event_on_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_on_o != $past(fan_on_o)) |-> event_o);
  assert_event_needs_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (fan_on_o != $past(fan_on_o)));
endmodule

// File: tb/tb_fan_ctrl_top.sv
module tb_fan_ctrl_top;
  localparam int N = 8;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [N*W-1:0] temps_i = '0;
  logic fan_on_o, event_o, shutdown_o;
  logic signed [W-1:0] peak_o, event_temp_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int cur [N];
  int m_fan = 0, m_peak = 0, m_evt = 0, m_evt_temp = 0;

  always #10 clk_i = ~clk_i;

  fan_ctrl_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .temps_i(temps_i),
    .fan_on_o(fan_on_o), .peak_o(peak_o), .event_o(event_o),
    .event_temp_o(event_temp_o), .shutdown_o(shutdown_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "fan_on_o", int'(fan_on_o), m_fan);
    chk(req, "peak_o", int'(peak_o), m_peak);
    chk(req, "event_o", int'(event_o), m_evt);
    chk(req, "event_temp_o", int'(event_temp_o), m_evt_temp);
    chk("R8", "shutdown_o", int'(shutdown_o), (m_peak >= 750) ? 1 : 0);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit v, string req);
    int mx;
    int nf;
    valid_i = v;
    for (int j = 0; j < N; j++) temps_i[j*W +: W] = W'(cur[j]);
    @(posedge clk_i);
    nf = m_fan;
    if (v) begin
      mx = cur[0];
      for (int j = 1; j < N; j++) if (cur[j] > mx) mx = cur[j];
      if (mx >= 700) nf = 1;
      else if (mx <= 600) nf = 0;
      m_peak = mx;
      if (nf != m_fan) m_evt_temp = mx;
    end
    m_evt = (nf != m_fan) ? 1 : 0;
    m_fan = nf;
    @(negedge clk_i);
    compare_all(req);
  endtask

  task automatic set_all(int v);
    for (int j = 0; j < N; j++) cur[j] = v;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    set_all(300);
    repeat (3) @(negedge clk_i);
    compare_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1");

    // cold start at 30.0 C: stays off
    step(1, "R3"); step(1, "R3");
    // dead band from below: stays off
    set_all(650); step(1, "R4");
    cur[5] = 699; step(1, "R4");
    // one sensor reaches 70.0 C
    cur[5] = 700; step(1, "R5");
    chk("R2", "fan_on after 700", int'(fan_on_o), 1);
    chk("R7", "event after 700", int'(event_o), 1);
    chk("R7", "event_temp after 700", int'(event_temp_o), 700);
    step(1, "R7");
    chk("R7", "pulse one cycle", int'(event_o), 0);
    // dead band from above: holds on
    set_all(601); step(1, "R4");
    chk("R4", "fan holds at 601", int'(fan_on_o), 1);
    // hot readings without strobe are ignored
    set_all(900); step(0, "R6"); step(0, "R6");
    chk("R6", "peak unchanged without strobe", int'(peak_o), 601);
    set_all(600); step(1, "R3");
    chk("R3", "fan off at 600", int'(fan_on_o), 0);
    chk("R7", "event_temp after 600", int'(event_temp_o), 600);
    // shutdown level, last sensor
    set_all(200); cur[7] = 749; step(1, "R8");
    chk("R8", "shutdown at 749", int'(shutdown_o), 0);
    cur[7] = 750; step(1, "R8");
    chk("R8", "shutdown at 750", int'(shutdown_o), 1);
    chk("R10", "fan on same cycle as peak", int'(fan_on_o), 1);
    // negative readings
    set_all(-400); cur[2] = -100; step(1, "R9");
    chk("R9", "signed peak", int'(peak_o), -100);
    chk("R3", "fan off when cold", int'(fan_on_o), 0);
    cur[0] = -1; step(1, "R9");
    // sweep across thresholds with gaps in the strobe
    for (int i = 0; i < 400; i++) begin
      for (int j = 0; j < N; j++) cur[j] = $urandom_range(820, 450) - 100;
      step(($urandom_range(3, 0) != 0), "R10");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule